// File: doc/BRIEF.md
# Three-Channel Measurement Scan and Snapshot Sequencer

This block shares one 12-bit converter between three measurement channels: a current-sense differential, the supply voltage and an auxiliary input. In its free-running mode a programmable tick starts one pass over all three channels, always in the same order. Each result lands in a pair of byte-wide data registers. The default tick count gives a pass rate of about 7.5 per second from a 50 MHz clock.

A host reaches the block through a small byte-wide register port. Offsets 0 to 5 hold the data bytes and offset 6 holds the control byte. The control byte can arm a one-shot measurement of a single channel. While that conversion is in flight, the channel shows a busy flag. When it finishes, the converter stays idle until the host re-arms. A test setting freezes the converter so that software can load the data bytes directly.

On the converter side the block issues a one-cycle start pulse with a channel code. It then waits for a done pulse that carries the 12-bit result.

Top module: `meas_scan_ctrl`

## Requirements
- R1: In free-running mode conversions are issued in the repeating order sense, supply, auxiliary, with `conv_chan` codes 0, 1 and 2.
- R2: Exactly one pass over the channels begins every TICK_DIV clock cycles while free-running.
- R3: The result of channel k (0 sense, 1 supply, 2 auxiliary) is stored with bits 11:4 at offset 2k and bits 3:0 in bits 7:4 of offset 2k+1. Bits 2:0 of offset 2k+1 read 0.
- R4: Reset clears all seven registers to 0. Offset 6 reads back the last control byte written. Its bit 7 is one-shot enable, bits 6:5 are the channel code and bit 4 is test mode.
- R5: A 0-to-1 change of control bit 7 with channel code 00, 01 or 10 issues exactly one conversion of that channel. The result is stored as in R3. Code 11 issues no conversion and sets no busy flag.
- R6: Bit 3 of offset 2k+1 is the busy flag of channel k. It reads 1 from the arming of a one-shot on that channel until the result is stored, then reads 0. No further conversion starts while bit 7 stays 1.
- R7: Writing the control byte while bit 7 is already 1 starts nothing and changes no data register. A new one-shot requires bit 7 to be written 0 and then 1.
- R8: All busy flags read 0 in free-running mode.
- R9: With control bit 4 set, no conversion starts, no result is stored, and host writes to offsets 0 to 5 take effect. In an odd offset only bits 7:4 are writable.
- R10: With control bit 4 clear, host writes to offsets 0 to 5 leave the data registers unchanged.
- R11: `conv_start` is a single-cycle pulse. It never rises while a conversion is outstanding, nor in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_addr | input | 3 | Host write offset (0-5 data, 6 control) |
| reg_wdata | input | 8 | Host write byte |
| reg_rd_addr | input | 3 | Host read offset |
| reg_rdata | output | 8 | Read byte for `reg_rd_addr` (combinational) |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_chan | output | 2 | Channel code of the current request |
| conv_done | input | 1 | One-cycle completion from the converter |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |

## Verification
The assertions assume a well-behaved converter. It raises `conv_done` exactly once per `conv_start`, at least one cycle after it, and never spontaneously. The bench keeps to this by modelling the converter as a fixed four-cycle latency source that only answers a start it has seen. Its result is taken from a per-channel value the bench sets. The bench also flags any start that lands on an outstanding conversion. Host writes are single-cycle strobes driven on the falling edge, so the control byte never changes in the same cycle as a data write.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int N_CH     = 3;
    localparam int CH_W     = 2;
    localparam int RES_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int LSB_W    = RES_W - BYTE_W;
    localparam int ADDR_W   = 3;
    localparam int N_DATA   = 2 * N_CH;
    localparam int CTL_ADDR = N_DATA;

    // control byte fields (decoded by the host side)
    localparam int CTL_ONESHOT = 7;
    localparam int CTL_CH_HI   = 6;
    localparam int CTL_CH_LO   = 5;
    localparam int CTL_TEST    = 4;

    typedef logic [CH_W-1:0] ch_t;
    localparam ch_t CH_SENSE  = 2'd0;
    localparam ch_t CH_SUPPLY = 2'd1;
    localparam ch_t CH_AUX    = 2'd2;
    localparam ch_t CH_NONE   = 2'd3;

    typedef enum logic {PH_IDLE, PH_CONV} phase_e;

    function automatic logic [N_CH-1:0] ch_mask(input ch_t c);
        logic [N_CH-1:0] m;
        m = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (c == ch_t'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int unsigned DIV = 6666667
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_s;

    tick_s tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (tk_q.cnt == LAST) begin
            tk_d.cnt  = '0;
            tk_d.tick = 1'b1;
        end else begin
            tk_d.cnt  = tk_q.cnt + CW'(1);
            tk_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick = tk_q.tick;

    generate
        if (DIV > 1) begin : g_tick_chk
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/scan_reg_file.sv
module scan_reg_file
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              upd_en,
    input  ch_t               upd_ch,
    input  logic [RES_W-1:0]  upd_val,
    input  logic [N_CH-1:0]   busy,
    output logic              snap_en,
    output ch_t               snap_ch,
    output logic              test_mode
);
    typedef struct packed {
        logic [N_CH-1:0][BYTE_W-1:0] hi;
        logic [N_CH-1:0][LSB_W-1:0]  lo;
        logic [BYTE_W-1:0]           ctl;
    } regs_s;

    regs_s rg_d, rg_q;
    logic  test_q;

    assign test_q = rg_q.ctl[CTL_TEST];

    always_comb begin
        rg_d = rg_q;
        if (wr_en && wr_addr == ADDR_W'(CTL_ADDR)) rg_d.ctl = wr_data;
        for (int i = 0; i < N_CH; i++) begin
            if (wr_en && test_q && wr_addr == ADDR_W'(2 * i))
                rg_d.hi[i] = wr_data;
            if (wr_en && test_q && wr_addr == ADDR_W'(2 * i + 1))
                rg_d.lo[i] = wr_data[BYTE_W-1 -: LSB_W];
            if (upd_en && !test_q && upd_ch == ch_t'(i)) begin
                rg_d.hi[i] = upd_val[RES_W-1 -: BYTE_W];
                rg_d.lo[i] = upd_val[LSB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTL_ADDR)) rd_data = rg_q.ctl;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_addr == ADDR_W'(2 * i))     rd_data = rg_q.hi[i];
            if (rd_addr == ADDR_W'(2 * i + 1))
                rd_data = {rg_q.lo[i], busy[i], {(BYTE_W-LSB_W-1){1'b0}}};
        end
    end

    assign snap_en   = rg_q.ctl[CTL_ONESHOT];
    assign snap_ch   = rg_q.ctl[CTL_CH_HI:CTL_CH_LO];
    assign test_mode = test_q;

    logic data_wr;
    assign data_wr = wr_en && (wr_addr < ADDR_W'(N_DATA));

    assert_host_wr_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !test_q && !upd_en) |=> ($stable(rg_q.hi) && $stable(rg_q.lo)));
    assert_test_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_q && !data_wr) |=> ($stable(rg_q.hi) && $stable(rg_q.lo)));
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            snap_en,
    input  ch_t             snap_ch,
    input  logic            test_mode,
    input  logic            conv_done,
    output logic            conv_start,
    output ch_t             conv_chan,
    output logic            upd_en,
    output ch_t             upd_ch,
    output logic [N_CH-1:0] busy
);
    typedef struct packed {
        phase_e          phase;
        ch_t             cur_ch;
        logic            is_snap;
        logic            scan_act;
        ch_t             scan_ch;
        logic            snap_pend;
        ch_t             snap_ch;
        logic [N_CH-1:0] busy;
        logic            en_prev;
        logic            start;
    } fsm_s;

    fsm_s sq_d, sq_q;
    logic arm;

    assign arm = snap_en && !sq_q.en_prev;

    always_comb begin
        sq_d         = sq_q;
        sq_d.start   = 1'b0;
        sq_d.en_prev = snap_en;

        if (arm && !test_mode && snap_ch != CH_NONE) begin
            sq_d.snap_pend = 1'b1;
            sq_d.snap_ch   = snap_ch;
            sq_d.busy      = sq_q.busy | ch_mask(snap_ch);
        end
        if (!snap_en && sq_q.snap_pend) begin
            sq_d.snap_pend = 1'b0;
            sq_d.busy      = sq_d.busy & ~ch_mask(sq_q.snap_ch);
        end
        if (tick && !snap_en && !test_mode && !sq_q.scan_act) begin
            sq_d.scan_act = 1'b1;
            sq_d.scan_ch  = CH_SENSE;
        end

        case (sq_q.phase)
            PH_IDLE: begin
                if (sq_q.snap_pend && snap_en && !test_mode) begin
                    sq_d.phase     = PH_CONV;
                    sq_d.cur_ch    = sq_q.snap_ch;
                    sq_d.is_snap   = 1'b1;
                    sq_d.snap_pend = 1'b0;
                    sq_d.start     = 1'b1;
                end else if (sq_q.scan_act) begin
                    if (snap_en || test_mode) begin
                        sq_d.scan_act = 1'b0;
                    end else begin
                        sq_d.phase   = PH_CONV;
                        sq_d.cur_ch  = sq_q.scan_ch;
                        sq_d.is_snap = 1'b0;
                        sq_d.start   = 1'b1;
                    end
                end
            end
            default: begin
                if (conv_done) begin
                    sq_d.phase = PH_IDLE;
                    if (sq_q.is_snap)
                        sq_d.busy = sq_d.busy & ~ch_mask(sq_q.cur_ch);
                    else if (sq_q.cur_ch == CH_AUX)
                        sq_d.scan_act = 1'b0;
                    else
                        sq_d.scan_ch = sq_q.cur_ch + ch_t'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign conv_start = sq_q.start;
    assign conv_chan  = sq_q.cur_ch;
    assign upd_en     = conv_done && (sq_q.phase == PH_CONV) && !test_mode;
    assign upd_ch     = sq_q.cur_ch;
    assign busy       = sq_q.busy;

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_gap_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_start);
    assert_no_code11_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != CH_NONE));
    assert_test_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> !conv_start);
    assert_busy_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.phase == PH_CONV && sq_q.is_snap && conv_done && !arm && !sq_q.snap_pend)
        |=> (busy == '0));
    assert_free_run_busy_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_en && !(sq_q.phase == PH_CONV && sq_q.is_snap)) |=> (busy == '0));
endmodule

// File: rtl/meas_scan_ctrl.sv
module meas_scan_ctrl
    import scan_pkg::*;
#(
    parameter int unsigned TICK_DIV = 6666667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);
    logic            tick;
    logic            snap_en;
    ch_t             snap_ch;
    logic            test_mode;
    logic            upd_en;
    ch_t             upd_ch;
    logic [N_CH-1:0] busy;

    scan_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    scan_reg_file regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wdata),
        .rd_addr  (reg_rd_addr),
        .rd_data  (reg_rdata),
        .upd_en   (upd_en),
        .upd_ch   (upd_ch),
        .upd_val  (conv_result),
        .busy     (busy),
        .snap_en  (snap_en),
        .snap_ch  (snap_ch),
        .test_mode(test_mode)
    );

    scan_seq_fsm seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .snap_en   (snap_en),
        .snap_ch   (snap_ch),
        .test_mode (test_mode),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .conv_chan (conv_chan),
        .upd_en    (upd_en),
        .upd_ch    (upd_ch),
        .busy      (busy)
    );
endmodule

// File: tb/meas_scan_ctrl_tb_top.sv
module meas_scan_ctrl_tb_top;
    localparam int TICK = 60;
    localparam int LAT  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_addr;
    logic [7:0]  reg_wdata;
    logic [2:0]  reg_rd_addr;
    logic [7:0]  reg_rdata;
    logic        conv_start;
    logic [1:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;

    always #10 clk = ~clk;

    meas_scan_ctrl #(.TICK_DIV(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    int n_chk = 0;
    int n_fail = 0;

    // fixed-latency converter model
    logic [11:0] model_val [3];
    int          lat_cnt;
    logic [1:0]  pend_ch;
    int          start_cnt;
    int          sense_cnt;
    int          overlap_err;
    logic        prev_start;
    logic [1:0]  chan_log [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= 0; conv_done <= 1'b0; start_cnt <= 0; sense_cnt <= 0;
            overlap_err <= 0; prev_start <= 1'b0; pend_ch <= 2'd0;
        end else begin
            conv_done  <= 1'b0;
            prev_start <= conv_start;
            if (conv_start) begin
                if (lat_cnt > 0 || prev_start) overlap_err <= overlap_err + 1;
                lat_cnt <= LAT;
                pend_ch <= conv_chan;
                chan_log[start_cnt % 64] <= conv_chan;
                start_cnt <= start_cnt + 1;
                if (conv_chan == 2'd0) sense_cnt <= sense_cnt + 1;
            end else if (lat_cnt > 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    conv_done   <= 1'b1;
                    conv_result <= model_val[pend_ch];
                end
            end
        end
    end

    localparam logic [35:0] VEC [4] = '{
        36'hABC_123_5F0, 36'hFFF_000_801, 36'h000_FFF_07F, 36'h5A5_A5A_3C3
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        reg_wr_addr = a; reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_rd_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] keep;
        logic [11:0] e;
        int s;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
        model_val[0] = '0; model_val[1] = '0; model_val[2] = '0;
        wait_cyc(4);
        // R4: reset state of all registers
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk8("R4 reset value", v, 8'h00);
        end
        chk8("R11 no start in reset", {7'd0, conv_start}, 8'h00);
        rst_n = 1'b1;

        // R3/R8: table of per-channel results in free-running mode
        for (int k = 0; k < 4; k++) begin
            model_val[0] = VEC[k][35:24];
            model_val[1] = VEC[k][23:12];
            model_val[2] = VEC[k][11:0];
            wait_cyc(2 * TICK + 30);
            for (int c = 0; c < 3; c++) begin
                e = model_val[c];
                rd(3'(2 * c), v);
                chk8("R3 msb byte", v, e[11:4]);
                rd(3'(2 * c + 1), v);
                chk8("R3 R8 lsb byte busy clear", v, {e[3:0], 4'h0});
            end
        end

        // R1: channel order
        for (int i = 0; i < 9; i++)
            chk_int("R1 scan order", int'(chan_log[i]), i % 3);

        // R2: one pass per tick period
        s = sense_cnt;
        wait_cyc(5 * TICK);
        chk_int("R2 passes in five periods", sense_cnt - s, 5);

        // R5/R6: one-shot on supply
        model_val[0] = 12'h111; model_val[1] = 12'h9A5; model_val[2] = 12'h222;
        wr(3'd6, 8'hA0);
        @(negedge clk);
        rd(3'd3, v);
        chk8("R6 busy set on armed channel", v & 8'h08, 8'h08);
        rd(3'd1, v);
        chk8("R6 busy clear on other channel", v & 8'h08, 8'h00);
        wait_cyc(40);
        rd(3'd2, v);
        chk8("R5 one-shot msb", v, 8'h9A);
        rd(3'd3, v);
        chk8("R5 R6 one-shot lsb busy cleared", v, 8'h50);
        chk_int("R5 one-shot channel", int'(chan_log[(start_cnt - 1) % 64]), 1);
        s = start_cnt;
        wait_cyc(150);
        chk_int("R6 converter halted", start_cnt, s);

        // R7: rewrite with bit 7 already set does nothing
        model_val[2] = 12'h3D4;
        rd(3'd4, keep);
        wr(3'd6, 8'hC0);
        wait_cyc(40);
        chk_int("R7 no start without re-arm", start_cnt, s);
        rd(3'd4, v);
        chk8("R7 aux data unchanged", v, keep);
        rd(3'd6, v);
        chk8("R4 control readback", v, 8'hC0);
        wr(3'd6, 8'h00);
        wr(3'd6, 8'hC0);
        wait_cyc(40);
        rd(3'd4, v);
        chk8("R7 re-armed aux msb", v, 8'h3D);
        rd(3'd5, v);
        chk8("R7 re-armed aux lsb", v, 8'h40);
        chk_int("R7 re-armed channel", int'(chan_log[(start_cnt - 1) % 64]), 2);

        // R5: code 11 issues nothing
        wr(3'd6, 8'h00);
        wr(3'd6, 8'hE0);
        wait_cyc(20);
        s = start_cnt;
        wait_cyc(150);
        chk_int("R5 code 11 no conversion", start_cnt, s);
        for (int c = 0; c < 3; c++) begin
            rd(3'(2 * c + 1), v);
            chk8("R5 code 11 no busy", v & 8'h0F, 8'h00);
        end

        // R8: busy zero while free-running
        wr(3'd6, 8'h00);
        wait_cyc(150);
        for (int c = 0; c < 3; c++) begin
            rd(3'(2 * c + 1), v);
            chk8("R8 free-run busy zero", v & 8'h0F, 8'h00);
        end

        // R9: test mode
        wr(3'd6, 8'h10);
        wait_cyc(20);
        s = start_cnt;
        wr(3'd0, 8'h5A);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h3C);
        rd(3'd0, v);
        chk8("R9 host write msb", v, 8'h5A);
        rd(3'd1, v);
        chk8("R9 host write lsb low bits fixed", v, 8'hF0);
        rd(3'd4, v);
        chk8("R9 host write aux msb", v, 8'h3C);
        model_val[0] = 12'hEEE; model_val[1] = 12'hEEE; model_val[2] = 12'hEEE;
        wait_cyc(150);
        rd(3'd0, v);
        chk8("R9 frozen msb", v, 8'h5A);
        rd(3'd1, v);
        chk8("R9 frozen lsb", v, 8'hF0);
        chk_int("R9 no start in test mode", start_cnt, s);
        rd(3'd6, v);
        chk8("R4 control readback test", v, 8'h10);

        // R10: host data write ignored outside test mode
        wr(3'd6, 8'h00);
        wr(3'd0, 8'h77);
        rd(3'd0, v);
        chk8("R10 host write ignored", v, 8'h5A);

        // R11: start never overlaps an outstanding conversion
        wait_cyc(2 * TICK);
        chk_int("R11 start overlap count", overlap_err, 0);

        finish_run();
    end
endmodule